// File: doc/BRIEF.md
# Password-Gated Protection Lock Bit

This block holds a single volatile lock flag. While the flag is set, the per-sector persistent protection bits of a non-volatile array must not be changed. While it is clear, they may be changed. How the flag behaves depends on a non-volatile mode input, `pwd_mode`.

- **Password mode** (`pwd_mode` = 1): every reset leaves the flag locked. The only way to unlock it is an unlock command that arrives together with a positive password-match result.
- **Persistent mode** (`pwd_mode` = 0): every reset leaves the flag unlocked. Once the flag is locked, only a reset unlocks it.

The surrounding command decoder supplies one-cycle strobes, and an external comparator supplies the match result. The block drives the flag and a registered modify-enable signal that gates writes to the protection-bit array.

All inputs are sampled on the rising edge of `clk`. Both `por` and `hw_rst` are synchronous, active-high requests. A command applied in the cycle before an edge is visible on `lock_q` and `mod_en` just after that edge.

Top module: `pwlock_top`

## Requirements
- R1: In the cycle after `por` is released, `lock_q` equals the `pwd_mode` value sampled at the last `por` edge, and `mod_en` is its inverse.
- R2: With `pwd_mode`=1, a `hw_rst` cycle leaves `lock_q`=1 after the edge.
- R3: With `pwd_mode`=0, a `hw_rst` cycle leaves `lock_q`=0 after the edge.
- R4: A `set_cmd` cycle without reset leaves `lock_q`=1 after the edge, in either mode.
- R5: With `pwd_mode`=1, an `unlock_cmd` cycle with `unlock_match`=1 and no set or reset leaves `lock_q`=0 after the edge.
- R6: With `pwd_mode`=1, an `unlock_cmd` cycle with `unlock_match`=0 leaves `lock_q` unchanged.
- R7: With `pwd_mode`=0, `unlock_cmd` has no effect on `lock_q`, whatever the value of `unlock_match`.
- R8: With no reset and no command, `lock_q` holds its value. In persistent mode, a set flag therefore stays set until `por` or `hw_rst`.
- R9: When `por` or `hw_rst` coincides with any command, the reset outcome of R1, R2 or R3 wins.
- R10: When `set_cmd` and a matching `unlock_cmd` coincide in password mode, `lock_q` ends at 1.
- R11: `mod_en` is a register output that equals the inverse of `lock_q` in every cycle after reset. The two change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-up reset request, active high |
| hw_rst | input | 1 | Synchronous hardware reset request, active high |
| pwd_mode | input | 1 | Non-volatile mode bit: 1 = password mode, 0 = persistent mode |
| set_cmd | input | 1 | Lock-set command strobe |
| unlock_cmd | input | 1 | Password-unlock command strobe |
| unlock_match | input | 1 | Password comparison result that accompanies `unlock_cmd` |
| lock_q | output | 1 | Lock flag |
| mod_en | output | 1 | Modify-enable for the protection bits, the registered inverse of the lock |

## Verification
The hardest states to reach are a cleared flag in password mode and a set flag in persistent mode, because no reset produces either one. The stimulus reaches each of these states from reset through a single command: a matching unlock for the first and a lock-set for the second. From all four (mode, flag) states, it then applies every one of the 32 combinations of the five control inputs. Each combination is checked against an arithmetic model that evaluates the priority order of the requirements.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
   // Resolved action for one cycle, after priority has been applied
   typedef enum logic [2:0] {
      ACT_HOLD   = 3'd0,
      ACT_RESET  = 3'd1,
      ACT_SET    = 3'd2,
      ACT_CLEAR  = 3'd3,
      ACT_REJECT = 3'd4
   } lock_act_e;
endpackage

// File: rtl/pwlock_arbiter.sv
module pwlock_arbiter
   import pwlock_pkg::*;
#(
   parameter int SET_OVER_UNLOCK = 1
) (
   input  logic      por,
   input  logic      hw_rst,
   input  logic      pwd_mode,
   input  logic      set_cmd,
   input  logic      unlock_cmd,
   input  logic      unlock_match,
   output lock_act_e act
);
   if (SET_OVER_UNLOCK != 0 && SET_OVER_UNLOCK != 1)
      $error("pwlock_arbiter: SET_OVER_UNLOCK must be 0 or 1");

   logic any_rst;
   logic unl_ok;
   logic unl_bad;

   assign any_rst = por | hw_rst;
   // an unlock is only meaningful in password mode
   assign unl_ok  = unlock_cmd & pwd_mode & unlock_match;
   assign unl_bad = unlock_cmd & pwd_mode & ~unlock_match;

   if (SET_OVER_UNLOCK == 1) begin : g_set_first
      always_comb begin
         if (any_rst)      act = ACT_RESET;
         else if (set_cmd) act = ACT_SET;
         else if (unl_ok)  act = ACT_CLEAR;
         else if (unl_bad) act = ACT_REJECT;
         else              act = ACT_HOLD;
      end
   end else begin : g_unlock_first
      always_comb begin
         if (any_rst)      act = ACT_RESET;
         else if (unl_ok)  act = ACT_CLEAR;
         else if (set_cmd) act = ACT_SET;
         else if (unl_bad) act = ACT_REJECT;
         else              act = ACT_HOLD;
      end
   end
endmodule

// File: rtl/pwlock_state.sv
module pwlock_state
   import pwlock_pkg::*;
(
   input  logic      clk,
   input  lock_act_e act,
   input  logic      pwd_mode,
   output logic      lock_d,
   output logic      lock_q
);
   always_comb begin
      unique case (act)
         ACT_RESET:  lock_d = pwd_mode;  // reset polarity follows the mode
         ACT_SET:    lock_d = 1'b1;
         ACT_CLEAR:  lock_d = 1'b0;
         ACT_REJECT: lock_d = lock_q;
         default:    lock_d = lock_q;
      endcase
   end

   always_ff @(posedge clk) begin
      lock_q <= lock_d;
   end
endmodule

// File: rtl/pwlock_enable.sv
module pwlock_enable (
   input  logic clk,
   input  logic lock_d,
   output logic mod_en
);
   // registered from the next-state value so it moves on the same edge as the lock
   always_ff @(posedge clk) begin
      mod_en <= ~lock_d;
   end
endmodule

// File: rtl/pwlock_top.sv
module pwlock_top
   import pwlock_pkg::*;
#(
   parameter int SET_OVER_UNLOCK = 1
) (
   input  logic clk,
   input  logic por,
   input  logic hw_rst,
   input  logic pwd_mode,
   input  logic set_cmd,
   input  logic unlock_cmd,
   input  logic unlock_match,
   output logic lock_q,
   output logic mod_en
);
   lock_act_e act;
   logic      lock_d;

   pwlock_arbiter #(.SET_OVER_UNLOCK(SET_OVER_UNLOCK)) u_arb (
      .por          (por),
      .hw_rst       (hw_rst),
      .pwd_mode     (pwd_mode),
      .set_cmd      (set_cmd),
      .unlock_cmd   (unlock_cmd),
      .unlock_match (unlock_match),
      .act          (act)
   );

   pwlock_state u_st (
      .clk      (clk),
      .act      (act),
      .pwd_mode (pwd_mode),
      .lock_d   (lock_d),
      .lock_q   (lock_q)
   );

   pwlock_enable u_en (
      .clk    (clk),
      .lock_d (lock_d),
      .mod_en (mod_en)
   );
endmodule

// File: rtl/pwlock_chk.sv
module pwlock_chk (
   input logic clk,
   input logic por,
   input logic hw_rst,
   input logic pwd_mode,
   input logic set_cmd,
   input logic unlock_cmd,
   input logic unlock_match,
   input logic lock_q,
   input logic mod_en
);
   p_por_mode_r1: assert property (@(posedge clk) disable iff (por)
      $fell(por) |-> (lock_q == $past(pwd_mode)) && (mod_en == !$past(pwd_mode)));

   p_hw_pwd_r2: assert property (@(posedge clk) disable iff (por)
      (hw_rst && pwd_mode) |=> lock_q);

   p_hw_pers_r3: assert property (@(posedge clk) disable iff (por)
      (hw_rst && !pwd_mode) |=> !lock_q);

   p_set_r4: assert property (@(posedge clk) disable iff (por)
      (set_cmd && !hw_rst) |=> lock_q);

   p_unlock_ok_r5: assert property (@(posedge clk) disable iff (por)
      (unlock_cmd && unlock_match && pwd_mode && !set_cmd && !hw_rst) |=> !lock_q);

   p_unlock_bad_r6: assert property (@(posedge clk) disable iff (por)
      (unlock_cmd && !unlock_match && !set_cmd && !hw_rst) |=> $stable(lock_q));

   p_pers_ignore_r7: assert property (@(posedge clk) disable iff (por)
      (!pwd_mode && !set_cmd && !hw_rst) |=> $stable(lock_q));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (por)
      (!set_cmd && !unlock_cmd && !hw_rst) |=> $stable(lock_q));

   p_rst_wins_r9: assert property (@(posedge clk) disable iff (por)
      (hw_rst && (set_cmd || unlock_cmd)) |=> (lock_q == $past(pwd_mode)));

   p_men_inverse_r11: assert property (@(posedge clk) disable iff (por)
      mod_en == !lock_q);
endmodule

bind pwlock_top pwlock_chk u_chk (
   .clk          (clk),
   .por          (por),
   .hw_rst       (hw_rst),
   .pwd_mode     (pwd_mode),
   .set_cmd      (set_cmd),
   .unlock_cmd   (unlock_cmd),
   .unlock_match (unlock_match),
   .lock_q       (lock_q),
   .mod_en       (mod_en)
);

// File: tb/sim_pwlock_top.sv
module sim_pwlock_top;
   logic clk = 1'b0;
   logic por = 1'b1;
   logic hw_rst = 1'b0;
   logic pwd_mode = 1'b1;
   logic set_cmd = 1'b0;
   logic unlock_cmd = 1'b0;
   logic unlock_match = 1'b0;
   logic lock_q;
   logic mod_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwlock_top u0 (
      .clk          (clk),
      .por          (por),
      .hw_rst       (hw_rst),
      .pwd_mode     (pwd_mode),
      .set_cmd      (set_cmd),
      .unlock_cmd   (unlock_cmd),
      .unlock_match (unlock_match),
      .lock_q       (lock_q),
      .mod_en       (mod_en)
   );

   // one full cycle: drive at a falling edge, return at the next falling edge
   task automatic cyc(input bit p, input bit h, input bit s, input bit u, input bit m);
      por = p; hw_rst = h; set_cmd = s; unlock_cmd = u; unlock_match = m;
      @(negedge clk);
      por = 0; hw_rst = 0; set_cmd = 0; unlock_cmd = 0; unlock_match = 0;
   endtask

   task automatic check(input string tag, input bit exp_lock);
      n_chk++;
      if (lock_q !== exp_lock) begin
         n_fail++;
         $display("FAIL %s lock_q actual=%b expected=%b", tag, lock_q, exp_lock);
      end
      n_chk++;
      if (mod_en !== !exp_lock) begin
         n_fail++;
         $display("FAIL R11 (%s) mod_en actual=%b expected=%b", tag, mod_en, !exp_lock);
      end
   endtask

   function automatic bit model(bit pw, bit cur, bit p, bit h, bit s, bit u, bit m);
      if (p || h) return pw;
      if (s) return 1'b1;
      if (u && pw && m) return 1'b0;
      return cur;
   endfunction

   function automatic string tag_of(bit pw, bit p, bit h, bit s, bit u, bit m);
      if (p || h) begin
         if (s || u) return "R9";
         if (p) return "R1";
         return pw ? "R2" : "R3";
      end
      if (s) return (u && pw && m) ? "R10" : "R4";
      if (u) begin
         if (!pw) return "R7";
         return m ? "R5" : "R6";
      end
      return "R8";
   endfunction

   initial begin
      @(negedge clk);
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      check("R1", 1'b1);   // password mode powers up locked
      for (int pw = 0; pw < 2; pw++) begin
         for (int start = 0; start < 2; start++) begin
            for (int v = 0; v < 32; v++) begin
               bit p, h, s, u, m, cur;
               pwd_mode = pw[0];
               cyc(1, 0, 0, 0, 0);
               cur = pw[0];
               if (start[0] != pw[0]) begin
                  // reach the state that no reset produces
                  if (pw[0]) cyc(0, 0, 0, 1, 1);
                  else       cyc(0, 0, 1, 0, 0);
                  cur = start[0];
               end
               check(pw[0] ? "R5" : "R4", cur);
               {p, h, s, u, m} = v[4:0];
               cyc(p, h, s, u, m);
               check(tag_of(pw[0], p, h, s, u, m), model(pw[0], cur, p, h, s, u, m));
               // follow-up idle cycle: value must persist (R8)
               cyc(0, 0, 0, 0, 0);
               check("R8", model(pw[0], cur, p, h, s, u, m));
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule